// File: doc/BRIEF.md
# FM Synthesizer Host-Bus Write Sequencer

This block sits between on-chip logic and the parallel host bus of an external FM synthesis device. Callers hand it write requests over a valid/ready handshake. Each request holds a 2-bit register-port address, an 8-bit value and a flag. The flag says whether the value is a register index (an address write) or register contents (a data write). The block drives the address and data lines and the active-low select and write strobes. It keeps the setup, strobe-width and hold windows, which are set in nanoseconds by parameters and rounded up to whole system-clock cycles.

After each write the device is busy for a number of its own clock cycles, and the sequencer keeps the next access back until that time has passed. An index write costs a short pause. A data write costs one of two longer pauses. The block picks between them from the most recent index it sent: indices at or above a channel-register threshold take the long pause, and lower indices take the medium pause. Out of reset the block also holds the device's active-low reset line low for a fixed number of device clocks before it accepts any request. One device clock lasts `CHIP_DIV` system clocks.

Top module: `fm_bus_writer`

## Requirements
- R1: After `rst` is released, `chip_reset_n` stays low for exactly 192 × CHIP_DIV system cycles (1344 with defaults) and then goes high. During that time `req_ready` is low and `chip_sel_n` and `chip_wr_n` are high.
- R2: `chip_rd_n` is always high. `chip_sel_n` and `chip_wr_n` are high whenever no strobe is in progress.
- R3: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the pause after that write has expired.
- R4: `chip_addr` and `chip_data` take the request's values in the cycle after acceptance. They are stable for ceil(SETUP_NS/CLK_NS) cycles (1 with defaults) before the strobes fall.
- R5: `chip_sel_n` and `chip_wr_n` fall together and stay low for ceil(STROBE_NS/CLK_NS) cycles (10 with defaults). Address and data do not change during the strobe.
- R6: After the strobes rise, `chip_addr` and `chip_data` keep their values until the next request is accepted, which covers at least the hold time.
- R7: After an index write (`req_is_index`=1), the cycles from the strobe rising to `req_ready` rising number 17 × CHIP_DIV (119).
- R8: After a data write whose remembered index is at or above 8'h30, the pause is 83 × CHIP_DIV (581) cycles.
- R9: After a data write whose remembered index is below 8'h30, the pause is 47 × CHIP_DIV (329) cycles.
- R10: The remembered index is loaded with the value of each accepted index write, and only by those writes. Data writes leave it unchanged. Its reset value is 8'hFF, so a data write issued before any index write takes the long pause.
- R11: A request presented while `req_ready` is low is neither dropped nor altered. It is accepted on the first edge where `req_ready` is high, and its own address and value are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_is_index | input | 1 | 1 = index (register address) write, 0 = data write |
| req_addr | input | 2 | Register-port address bits |
| req_value | input | 8 | Index or data byte |
| chip_addr | output | 2 | Device address lines |
| chip_data | output | 8 | Device data lines |
| chip_sel_n | output | 1 | Device select, active low |
| chip_wr_n | output | 1 | Device write strobe, active low |
| chip_rd_n | output | 1 | Device read strobe, held high |
| chip_reset_n | output | 1 | Device reset, active low |

## Verification
Two functions can fall in the same cycle: the pause of one write expires and a request that has been stalled is accepted. The stall case tests this. The bench keeps `req_valid` high with a new request from the cycle after the previous acceptance. It then checks that the old values stay on the lines through strobe and pause, and that the new request is accepted on the edge right after `req_ready` returns with its own values. The index-memory update and the pause selection for the next data write also meet. Index values just below and at the channel threshold, data writes placed between index writes, and random mixes are each judged against the pause length the bench computes.

// File: rtl/fm_bus_pkg.sv
package fm_bus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_GAP    = 2'd3
    } phase_e;

    typedef struct packed {
        logic       is_index;
        logic [1:0] addr;
        logic [7:0] value;
    } wr_req_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned count_width(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/fm_reset_gen.sv
module fm_reset_gen #(
    parameter int unsigned RST_CYC = 1344,
    parameter int unsigned CW      = 11
) (
    input  logic clk,
    input  logic rst,
    output logic done
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == CW'(RST_CYC - 1)) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_RESET_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        !done |-> (cnt < CW'(RST_CYC))); // R1

    AST_RESET_STAYS_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> done); // R1

endmodule

// File: rtl/fm_phase_timer.sv
module fm_phase_timer #(
    parameter int unsigned CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_len,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_len - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_len != '0)); // R7

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R5

endmodule

// File: rtl/fm_wait_select.sv
module fm_wait_select
    import fm_bus_pkg::*;
#(
    parameter int unsigned CW        = 11,
    parameter int unsigned IDX_CYC   = 119,
    parameter int unsigned LONG_CYC  = 581,
    parameter int unsigned SHORT_CYC = 329,
    parameter logic [7:0]  CHAN_BASE = 8'h30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  wr_req_t       req,
    output logic [CW-1:0] gap_len
);

    logic [7:0] last_index;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_index <= 8'hFF;
        end else if (capture && req.is_index) begin
            last_index <= req.value;
        end
    end

    always_comb begin
        if (req.is_index) begin
            gap_len = CW'(IDX_CYC);
        end else if (last_index >= CHAN_BASE) begin
            gap_len = CW'(LONG_CYC);
        end else begin
            gap_len = CW'(SHORT_CYC);
        end
    end

    AST_DATA_KEEPS_INDEX: assert property (@(posedge clk) disable iff (rst)
        (capture && !req.is_index) |=> $stable(last_index)); // R10

    AST_IDLE_KEEPS_INDEX: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(last_index)); // R10

endmodule

// File: rtl/fm_bus_writer.sv
module fm_bus_writer
    import fm_bus_pkg::*;
#(
    parameter int unsigned CLK_NS      = 20,
    parameter int unsigned CHIP_DIV    = 7,
    parameter int unsigned SETUP_NS    = 10,
    parameter int unsigned STROBE_NS   = 200,
    parameter int unsigned HOLD_NS     = 10,
    parameter int unsigned IDX_GAP     = 17,
    parameter int unsigned LONG_GAP    = 83,
    parameter int unsigned SHORT_GAP   = 47,
    parameter int unsigned RESET_CHIP  = 192,
    parameter logic [7:0]  CHAN_BASE   = 8'h30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_is_index,
    input  logic [1:0] req_addr,
    input  logic [7:0] req_value,
    output logic [1:0] chip_addr,
    output logic [7:0] chip_data,
    output logic       chip_sel_n,
    output logic       chip_wr_n,
    output logic       chip_rd_n,
    output logic       chip_reset_n
);

    localparam int unsigned SU_CYC    = max2(1, ceil_div(SETUP_NS, CLK_NS));
    localparam int unsigned PW_CYC    = max2(1, ceil_div(STROBE_NS, CLK_NS));
    localparam int unsigned HOLD_CYC  = max2(1, ceil_div(HOLD_NS, CLK_NS));
    localparam int unsigned IDX_CYC   = max2(HOLD_CYC, IDX_GAP * CHIP_DIV);
    localparam int unsigned LONG_CYC  = max2(HOLD_CYC, LONG_GAP * CHIP_DIV);
    localparam int unsigned SHORT_CYC = max2(HOLD_CYC, SHORT_GAP * CHIP_DIV);
    localparam int unsigned RST_CYC   = max2(1, RESET_CHIP * CHIP_DIV);
    localparam int unsigned MAX_CYC   = max2(max2(max2(SU_CYC, PW_CYC), max2(IDX_CYC, LONG_CYC)),
                                             max2(SHORT_CYC, RST_CYC));
    localparam int unsigned CW        = count_width(MAX_CYC);

    phase_e        phase;
    wr_req_t       incoming;
    wr_req_t       held;
    logic          strobe_n;
    logic          init_done;
    logic          accept;
    logic          tmr_load;
    logic [CW-1:0] tmr_len;
    logic          tmr_expired;
    logic [CW-1:0] gap_len;
    logic [CW-1:0] gap_q;

    assign incoming  = '{is_index: req_is_index, addr: req_addr, value: req_value};
    assign req_ready = init_done && (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    fm_reset_gen #(
        .RST_CYC (RST_CYC),
        .CW      (CW)
    ) u_reset_gen (
        .clk  (clk),
        .rst  (rst),
        .done (init_done)
    );

    fm_wait_select #(
        .CW        (CW),
        .IDX_CYC   (IDX_CYC),
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC),
        .CHAN_BASE (CHAN_BASE)
    ) u_wait_select (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .req     (incoming),
        .gap_len (gap_len)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_len  = CW'(SU_CYC);
        if (accept) begin
            tmr_load = 1'b1;
            tmr_len  = CW'(SU_CYC);
        end else if (phase == PH_SETUP && tmr_expired) begin
            tmr_load = 1'b1;
            tmr_len  = CW'(PW_CYC);
        end else if (phase == PH_STROBE && tmr_expired) begin
            tmr_load = 1'b1;
            tmr_len  = gap_q;
        end
    end

    fm_phase_timer #(
        .CW (CW)
    ) u_phase_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_len (tmr_len),
        .expired  (tmr_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            held     <= '0;
            strobe_n <= 1'b1;
            gap_q    <= CW'(IDX_CYC);
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase <= PH_SETUP;
                        held  <= incoming;
                        gap_q <= gap_len;
                    end
                end
                PH_SETUP: begin
                    if (tmr_expired) begin
                        phase    <= PH_STROBE;
                        strobe_n <= 1'b0;
                    end
                end
                PH_STROBE: begin
                    if (tmr_expired) begin
                        phase    <= PH_GAP;
                        strobe_n <= 1'b1;
                    end
                end
                PH_GAP: begin
                    if (tmr_expired) begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign chip_addr    = held.addr;
    assign chip_data    = held.value;
    assign chip_sel_n   = strobe_n;
    assign chip_wr_n    = strobe_n;
    assign chip_rd_n    = 1'b1;
    assign chip_reset_n = init_done;

    AST_NO_STROBE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        !chip_reset_n |-> (chip_sel_n && !req_ready)); // R1

    AST_READ_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        chip_rd_n); // R2

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready); // R3

    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_sel_n) |-> ($stable(chip_addr) && $stable(chip_data))); // R4

    AST_STABLE_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!chip_sel_n && $past(!chip_sel_n)) |-> ($stable(chip_addr) && $stable(chip_data))); // R5

    AST_NOT_READY_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        !chip_sel_n |-> !req_ready); // R3

    AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(chip_sel_n) |-> ($stable(chip_addr) && $stable(chip_data))); // R6

    AST_LINES_FROZEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(accept) |-> ($stable(chip_addr) && $stable(chip_data))); // R6

endmodule

// File: tb/fm_bus_writer_bench.sv
`timescale 1ns/1ps
module fm_bus_writer_bench;

    localparam int SU    = 1;
    localparam int PW    = 10;
    localparam int IDXG  = 17 * 7;
    localparam int LONGG = 83 * 7;
    localparam int SHRTG = 47 * 7;
    localparam int RSTC  = 192 * 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_is_index = 1'b0;
    logic [1:0] req_addr = '0;
    logic [7:0] req_value = '0;
    logic [1:0] chip_addr;
    logic [7:0] chip_data;
    logic       chip_sel_n, chip_wr_n, chip_rd_n, chip_reset_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] model_index = 8'hFF;

    always #10 clk = ~clk;

    fm_bus_writer u_fm_bus_writer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_index(req_is_index), .req_addr(req_addr), .req_value(req_value),
        .chip_addr(chip_addr), .chip_data(chip_data), .chip_sel_n(chip_sel_n),
        .chip_wr_n(chip_wr_n), .chip_rd_n(chip_rd_n), .chip_reset_n(chip_reset_n)
    );

    task automatic chk(input bit ok, input string tag, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    function automatic int exp_gap(input bit idx, input logic [7:0] last);
        if (idx) return IDXG;
        return (last >= 8'h30) ? LONGG : SHRTG;
    endfunction

    function automatic string gap_tag(input bit idx, input logic [7:0] last);
        if (idx) return "R7 index pause";
        return (last >= 8'h30) ? "R8 long data pause" : "R9 short data pause";
    endfunction

    // drive a request and return at the negedge after it was accepted; valid stays high
    task automatic issue(input bit idx, input logic [1:0] a, input logic [7:0] v);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_is_index = idx; req_addr = a; req_value = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    // watch one write from the cycle after acceptance until ready returns
    task automatic observe(input bit idx, input logic [1:0] a, input logic [7:0] v);
        int n, p, g, eg;
        string tg;
        eg = exp_gap(idx, model_index);
        tg = gap_tag(idx, model_index);
        n = 0;
        while (chip_sel_n && n < 50) begin
            chk(chip_addr == a && chip_data == v, "R4 lines set before strobe", int'(chip_data), int'(v));
            chk(!req_ready && chip_wr_n, "R3 busy in setup", int'(req_ready), 0);
            n++;
            @(negedge clk);
        end
        chk(n == SU, "R4 setup cycles", n, SU);
        p = 0;
        while (!chip_sel_n && p < 50) begin
            chk(!chip_wr_n, "R5 write strobe with select", int'(chip_wr_n), 0);
            chk(chip_addr == a && chip_data == v, "R5 lines stable in strobe", int'(chip_data), int'(v));
            chk(!req_ready, "R3 busy in strobe", int'(req_ready), 0);
            p++;
            @(negedge clk);
        end
        chk(p == PW, "R5 strobe width", p, PW);
        g = 0;
        while (!req_ready && g < 1000) begin
            chk(chip_sel_n && chip_wr_n && chip_rd_n, "R2 strobes idle in pause", int'(chip_sel_n), 1);
            chk(chip_addr == a && chip_data == v, "R6 hold after strobe", int'(chip_data), int'(v));
            g++;
            @(negedge clk);
        end
        chk(g == eg, tg, g, eg);
        if (idx) model_index = v;
    endtask

    task automatic one_write(input bit idx, input logic [1:0] a, input logic [7:0] v);
        issue(idx, a, v);
        req_valid = 1'b0;
        observe(idx, a, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd31337);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset pulse length
        k = 0;
        while (!chip_reset_n && k < RSTC + 10) begin
            if (!(req_ready == 1'b0 && chip_sel_n && chip_wr_n))
                chk(1'b0, "R1 quiet during reset", int'(req_ready), 0);
            k++;
            @(negedge clk);
        end
        chk(k == RSTC, "R1 reset pulse cycles", k, RSTC);
        chk(chip_reset_n == 1'b1, "R1 reset released", int'(chip_reset_n), 1);
        chk(req_ready == 1'b1, "R3 ready after reset", int'(req_ready), 1);
        chk(chip_sel_n && chip_wr_n && chip_rd_n, "R2 idle strobes high", int'(chip_sel_n), 1);

        // R10: data write before any index uses reset index 8'hFF -> long pause
        one_write(1'b0, 2'd1, 8'h5A);
        // R9 boundary: index just below threshold
        one_write(1'b1, 2'd0, 8'h2F);
        one_write(1'b0, 2'd1, 8'hC3);
        // R10: data write does not alter remembered index (still short)
        one_write(1'b0, 2'd1, 8'h90);
        // R8 boundary: index at threshold
        one_write(1'b1, 2'd2, 8'h30);
        one_write(1'b0, 2'd3, 8'h01);

        // R6: lines keep last values while idle; R2 strobes high
        repeat (5) @(negedge clk);
        chk(chip_addr == 2'd3 && chip_data == 8'h01, "R6 lines held while idle", int'(chip_data), 1);
        chk(chip_sel_n && chip_wr_n && chip_rd_n, "R2 idle strobes high", int'(chip_wr_n), 1);

        // R11: next request waits with valid high through the whole busy period
        issue(1'b1, 2'd0, 8'h40);
        req_is_index = 1'b0; req_addr = 2'd1; req_value = 8'hA7;
        observe(1'b1, 2'd0, 8'h40);
        chk(req_ready && req_valid, "R11 stalled request pending at ready", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        observe(1'b0, 2'd1, 8'hA7);

        // random mix
        for (int i = 0; i < 24; i++) begin
            bit idx;
            logic [1:0] a;
            logic [7:0] v;
            idx = ($urandom % 3) == 0;
            a = 2'($urandom);
            v = 8'($urandom);
            if (idx && ($urandom % 2 == 0)) v = 8'($urandom % 8'h30);
            one_write(idx, a, v);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule